// File: doc/BRIEF.md
# Inline ECC Address and Lane Mapper

This block sits between a system-side memory port and a memory controller that keeps check bytes inline with the data. Every check byte shares the physical word with its data byte. Each cycle it takes a 32-bit system address, a transfer size, a 32-bit write word and four check bytes. It sorts the address into one of three windows: a protected window, a shadow window placed directly above it, or neither. It then produces the physical address, the physical transfer size, the 64-bit physical write word and the physical byte enables. A protected access occupies twice its system footprint. Each data byte is followed by its check byte. A shadow access reaches one chosen half of that doubled physical image without any check-byte handling, so it can be used to read or corrupt the stored check bytes directly.

The window bounds and the shadow-half select are loaded through a configuration strobe. A load whose bounds are not multiples of 64 KB is refused and flagged. A 64-bit word read back from memory is split into its four data bytes and its four check bytes. Every output is registered, so it reflects the inputs of the previous clock edge.

Top module: `ecc_inline_mapper`

## Requirements
- R1: During reset every output is zero. After reset both bounds are zero, so the protected window is empty and the shadow-half select is 1. An access in that state reports region code 0 and keeps its own address.
- R2: A configuration load takes effect only when bits [15:0] of both bounds are zero. Otherwise the stored bounds and select stay unchanged, and `cfg_reject_o` is 1 in the cycle after the load.
- R3: Region code 1 (protected) is reported when min <= address < max. The maximum bound itself is not protected. Codes are 0 = neither, 1 = protected, 2 = shadow, and code 3 never appears.
- R4: A protected access maps to physical address min + 2*(address - min). A size code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) of 0 to 2 is raised by one. Code 3 stays 3.
- R5: For a protected access, physical byte 2i carries write byte i and physical byte 2i+1 carries check byte i (check byte i is `wr_chk_i[8i+7:8i]`). For example, 0x11223344 with checks 0xC99039ED becomes 0xC9119022_3933ED44.
- R6: For a protected access, system lane i is enabled when (i >> size) equals (address[1:0] >> size). Each enabled lane i drives physical byte enables 2i and 2i+1, and all eight are driven for size 3.
- R7: Region code 2 (shadow) is reported when max <= address < max + (max - min).
- R8: With the select at 1, a shadow access keeps its own address, so 0xA0000000 reaches the physical image of 0x90000000 in a 0x80000000 to 0xA0000000 window. With the select at 0, it maps to min + (address - max).
- R9: For shadow and unmapped accesses, the check bytes have no effect. The write word is repeated in both halves of the physical word, the size is unchanged, and physical byte k is enabled when (k >> size) equals (address[2:0] >> size).
- R10: An access in neither window keeps its address and size unchanged.
- R11: The 64-bit read word is split so that `rd_data_o` byte i is physical byte 2i and `rd_chk_o` byte i is physical byte 2i+1. This result appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load strobe for bounds and select |
| cfg_min_i | input | 32 | Protected window lower bound (inclusive) |
| cfg_max_i | input | 32 | Protected window upper bound (exclusive) |
| cfg_shadow_hi_i | input | 1 | Shadow half select: 1 upper half, 0 lower half |
| cfg_reject_o | output | 1 | Previous load was refused as misaligned |
| sys_addr_i | input | 32 | System byte address |
| sys_size_i | input | 2 | System size code, 0..3 = 8..64 bits |
| wr_word_i | input | 32 | System write word |
| wr_chk_i | input | 32 | Four check bytes, one per data byte |
| rd_phys_i | input | 64 | Physical word read from memory |
| region_o | output | 2 | Region code of the previous access |
| phys_addr_o | output | 32 | Physical byte address |
| phys_size_o | output | 2 | Physical size code |
| phys_wdata_o | output | 64 | Physical write word |
| phys_be_o | output | 8 | Physical byte enables |
| rd_data_o | output | 32 | Data bytes split from the read word |
| rd_chk_o | output | 32 | Check bytes split from the read word |

## Verification
A wrong stored bound or a wrong shadow select shows up on the next access near a window edge. The access is misclassified on `region_o`, and `phys_addr_o` moves by the window span, one cycle after it is presented. A lane slip in the interleave or byte-enable logic corrupts `phys_wdata_o` or `phys_be_o` in that same cycle. The tests therefore probe addresses at min, at max - 1, at max, and at the shadow end, under both select values. A refused load that still changes the bounds is seen on the first protected access that follows.

// File: rtl/ecc_map_pkg.sv
package ecc_map_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'b00,
    RGN_PROT = 2'b01,
    RGN_SHAD = 2'b10
  } region_e;
endpackage

// File: rtl/ecc_map_cfg.sv
module ecc_map_cfg #(
  parameter int AW        = 32,
  parameter int GRAN_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] min_i,
  input  logic [AW-1:0] max_i,
  input  logic          sel_hi_i,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q,
  output logic          sel_hi_q,
  output logic          reject_q
);
  localparam int UW = AW - GRAN_BITS;

  logic [UW-1:0] lo_up_q, hi_up_q;
  logic          bounds_aligned;
  logic          load_ok;

  assign bounds_aligned = ~|min_i[GRAN_BITS-1:0] && ~|max_i[GRAN_BITS-1:0];
  assign load_ok        = load_i && bounds_aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_up_q  <= '0;
      hi_up_q  <= '0;
      sel_hi_q <= 1'b1;
      reject_q <= 1'b0;
    end else begin
      reject_q <= load_i && !bounds_aligned;
      if (load_ok) begin
        lo_up_q  <= min_i[AW-1:GRAN_BITS];
        hi_up_q  <= max_i[AW-1:GRAN_BITS];
        sel_hi_q <= sel_hi_i;
      end
    end
  end

  assign lo_q = {lo_up_q, {GRAN_BITS{1'b0}}};
  assign hi_q = {hi_up_q, {GRAN_BITS{1'b0}}};
endmodule

// File: rtl/ecc_map_classify.sv
module ecc_map_classify
  import ecc_map_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          in_prot_o,
  output logic          in_shad_o,
  output region_e       region_o
);
  logic [AW:0] span;
  logic [AW:0] shad_end;

  function automatic logic [AW:0] window_span(input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    return (hi > lo) ? ({1'b0, hi} - {1'b0, lo}) : '0;
  endfunction

  assign span      = window_span(lo_i, hi_i);
  assign shad_end  = {1'b0, hi_i} + span;
  assign in_prot_o = (addr_i >= lo_i) && (addr_i < hi_i);
  assign in_shad_o = !in_prot_o && (addr_i >= hi_i) && ({1'b0, addr_i} < shad_end);

  always_comb begin
    if (in_prot_o)      region_o = RGN_PROT;
    else if (in_shad_o) region_o = RGN_SHAD;
    else                region_o = RGN_NONE;
  end
endmodule

// File: rtl/ecc_map_xlate.sv
module ecc_map_xlate
  import ecc_map_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  lo_i,
  input  logic [AW-1:0]  hi_i,
  input  logic           sel_hi_i,
  input  region_e        region_i,
  input  logic [SZW-1:0] size_i,
  output logic [AW-1:0]  paddr_o,
  output logic [SZW-1:0] psize_o
);
  function automatic logic [AW-1:0] prot_phys(input logic [AW-1:0] a, input logic [AW-1:0] lo);
    return lo + ((a - lo) << 1);
  endfunction

  function automatic logic [AW-1:0] shad_phys(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                               input logic [AW-1:0] hi, input logic sel);
    return sel ? a : (lo + (a - hi));
  endfunction

  function automatic logic [SZW-1:0] widen(input logic [SZW-1:0] sz);
    return (sz == {SZW{1'b1}}) ? sz : sz + 1'b1;
  endfunction

  always_comb begin
    unique case (region_i)
      RGN_PROT: begin
        paddr_o = prot_phys(addr_i, lo_i);
        psize_o = widen(size_i);
      end
      RGN_SHAD: begin
        paddr_o = shad_phys(addr_i, lo_i, hi_i, sel_hi_i);
        psize_o = size_i;
      end
      default: begin
        paddr_o = addr_i;
        psize_o = size_i;
      end
    endcase
  end
endmodule

// File: rtl/ecc_map_lanes.sv
module ecc_map_lanes #(
  parameter int DW  = 32,
  parameter int SZW = 2,
  parameter int PB  = 3
) (
  input  logic              prot_i,
  input  logic [PB-1:0]     off_i,
  input  logic [SZW-1:0]    size_i,
  input  logic [DW-1:0]     wr_word_i,
  input  logic [DW-1:0]     wr_chk_i,
  input  logic [2*DW-1:0]   rd_phys_i,
  output logic [2*DW-1:0]   wdata_o,
  output logic [2*DW/8-1:0] be_o,
  output logic [DW-1:0]     rd_data_o,
  output logic [DW-1:0]     rd_chk_o
);
  localparam int NL = DW / 8;
  localparam int PL = 2 * NL;
  localparam int OB = PB - 1;

  logic [NL-1:0]   sys_be;
  logic [PL-1:0]   prot_be;
  logic [2*DW-1:0] packed_w;

  function automatic logic [NL-1:0] sys_mask(input logic [OB-1:0] off, input logic [SZW-1:0] sz);
    logic [NL-1:0] m;
    m = '0;
    for (int i = 0; i < NL; i++) m[i] = ((i >> sz) == (int'(off) >> sz));
    return m;
  endfunction

  function automatic logic [PL-1:0] raw_mask(input logic [PB-1:0] off, input logic [SZW-1:0] sz);
    logic [PL-1:0] m;
    m = '0;
    for (int k = 0; k < PL; k++) m[k] = ((k >> sz) == (int'(off) >> sz));
    return m;
  endfunction

  assign sys_be = sys_mask(off_i[OB-1:0], size_i);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign packed_w[16*g +: 8]   = wr_word_i[8*g +: 8];
    assign packed_w[16*g+8 +: 8] = wr_chk_i[8*g +: 8];
    assign prot_be[2*g]          = sys_be[g];
    assign prot_be[2*g+1]        = sys_be[g];
    assign rd_data_o[8*g +: 8]   = rd_phys_i[16*g +: 8];
    assign rd_chk_o[8*g +: 8]    = rd_phys_i[16*g+8 +: 8];
  end

  assign wdata_o = prot_i ? packed_w : {wr_word_i, wr_word_i};
  assign be_o    = prot_i ? prot_be  : raw_mask(off_i, size_i);
endmodule

// File: rtl/ecc_inline_mapper.sv
module ecc_inline_mapper
  import ecc_map_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int GRAN_BITS = 16,
  localparam int NL  = DATA_W / 8,
  localparam int OB  = $clog2(NL),
  localparam int PB  = OB + 1,
  localparam int SZW = $clog2(PB + 1),
  localparam int PW  = 2 * DATA_W,
  localparam int PL  = 2 * NL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] cfg_min_i,
  input  logic [ADDR_W-1:0] cfg_max_i,
  input  logic              cfg_shadow_hi_i,
  output logic              cfg_reject_o,
  input  logic [ADDR_W-1:0] sys_addr_i,
  input  logic [SZW-1:0]    sys_size_i,
  input  logic [DATA_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_chk_i,
  input  logic [PW-1:0]     rd_phys_i,
  output logic [1:0]        region_o,
  output logic [ADDR_W-1:0] phys_addr_o,
  output logic [SZW-1:0]    phys_size_o,
  output logic [PW-1:0]     phys_wdata_o,
  output logic [PL-1:0]     phys_be_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] rd_chk_o
);
  logic [ADDR_W-1:0] win_lo, win_hi;
  logic              shad_sel_hi;
  logic              hit_prot, hit_shad;
  region_e           region_d;
  logic [ADDR_W-1:0] paddr_d;
  logic [SZW-1:0]    psize_d;
  logic [PW-1:0]     wdata_d;
  logic [PL-1:0]     be_d;
  logic [DATA_W-1:0] rdata_d, rchk_d;

  ecc_map_cfg #(.AW(ADDR_W), .GRAN_BITS(GRAN_BITS)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
    .min_i(cfg_min_i), .max_i(cfg_max_i), .sel_hi_i(cfg_shadow_hi_i),
    .lo_q(win_lo), .hi_q(win_hi), .sel_hi_q(shad_sel_hi), .reject_q(cfg_reject_o)
  );

  ecc_map_classify #(.AW(ADDR_W)) cls_i (
    .addr_i(sys_addr_i), .lo_i(win_lo), .hi_i(win_hi),
    .in_prot_o(hit_prot), .in_shad_o(hit_shad), .region_o(region_d)
  );

  ecc_map_xlate #(.AW(ADDR_W), .SZW(SZW)) xl_i (
    .addr_i(sys_addr_i), .lo_i(win_lo), .hi_i(win_hi), .sel_hi_i(shad_sel_hi),
    .region_i(region_d), .size_i(sys_size_i), .paddr_o(paddr_d), .psize_o(psize_d)
  );

  ecc_map_lanes #(.DW(DATA_W), .SZW(SZW), .PB(PB)) ln_i (
    .prot_i(hit_prot), .off_i(sys_addr_i[PB-1:0]), .size_i(sys_size_i),
    .wr_word_i(wr_word_i), .wr_chk_i(wr_chk_i), .rd_phys_i(rd_phys_i),
    .wdata_o(wdata_d), .be_o(be_d), .rd_data_o(rdata_d), .rd_chk_o(rchk_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_o     <= '0;
      phys_addr_o  <= '0;
      phys_size_o  <= '0;
      phys_wdata_o <= '0;
      phys_be_o    <= '0;
      rd_data_o    <= '0;
      rd_chk_o     <= '0;
    end else begin
      region_o     <= region_d;
      phys_addr_o  <= paddr_d;
      phys_size_o  <= psize_d;
      phys_wdata_o <= wdata_d;
      phys_be_o    <= be_d;
      rd_data_o    <= rdata_d;
      rd_chk_o     <= rchk_d;
    end
  end
endmodule

// File: rtl/ecc_map_chk.sv
module ecc_map_chk
  import ecc_map_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int GRAN_BITS = 16,
  parameter int SZW       = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_load_i,
  input logic [ADDR_W-1:0]   cfg_min_i,
  input logic [ADDR_W-1:0]   cfg_max_i,
  input logic                cfg_reject_o,
  input logic                shad_sel_hi,
  input logic                hit_shad,
  input logic [ADDR_W-1:0]   sys_addr_i,
  input logic [SZW-1:0]      sys_size_i,
  input logic [DATA_W-1:0]   wr_word_i,
  input logic [2*DATA_W-1:0] rd_phys_i,
  input logic [1:0]          region_o,
  input logic [ADDR_W-1:0]   phys_addr_o,
  input logic [SZW-1:0]      phys_size_o,
  input logic [2*DATA_W-1:0] phys_wdata_o,
  input logic [DATA_W/4-1:0] phys_be_o,
  input logic [DATA_W-1:0]   rd_data_o
);
  localparam int PL = DATA_W / 4;

  function automatic logic [PL-1:0] even_bits();
    logic [PL-1:0] m;
    m = '0;
    for (int i = 0; i < PL; i += 2) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [PL-1:0] EVEN = even_bits();

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_reject_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cfg_load_i && (|cfg_min_i[GRAN_BITS-1:0] || |cfg_max_i[GRAN_BITS-1:0]))
    |-> cfg_reject_o);

  a_r3_region_legal: assert property (@(posedge clk) disable iff (!rst_n)
    region_o != 2'b11);

  a_r4_prot_size: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_PROT && $past(sys_size_i) != {SZW{1'b1}}
    |-> phys_size_o == $past(sys_size_i) + 1'b1);

  a_r5_prot_data_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_PROT
    |-> phys_wdata_o[7:0] == $past(wr_word_i[7:0]) && phys_wdata_o[23:16] == $past(wr_word_i[15:8]));

  a_r6_prot_be_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    region_o == RGN_PROT |-> (phys_be_o & EVEN) == ((phys_be_o >> 1) & EVEN));

  a_r7_shadow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_SHAD |-> $past(hit_shad));

  a_r8_shadow_hi_identity: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_SHAD && $past(shad_sel_hi) |-> phys_addr_o == $past(sys_addr_i));

  a_r9_shadow_raw_data: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_SHAD |-> phys_wdata_o == {$past(wr_word_i), $past(wr_word_i)});

  a_r10_none_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && region_o == RGN_NONE
    |-> phys_addr_o == $past(sys_addr_i) && phys_size_o == $past(sys_size_i));

  a_r11_unpack_low: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rd_data_o[7:0] == $past(rd_phys_i[7:0]));
endmodule

bind ecc_inline_mapper ecc_map_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_BITS(GRAN_BITS), .SZW(SZW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i), .cfg_min_i(cfg_min_i),
  .cfg_max_i(cfg_max_i), .cfg_reject_o(cfg_reject_o), .shad_sel_hi(shad_sel_hi),
  .hit_shad(hit_shad), .sys_addr_i(sys_addr_i), .sys_size_i(sys_size_i),
  .wr_word_i(wr_word_i), .rd_phys_i(rd_phys_i), .region_o(region_o),
  .phys_addr_o(phys_addr_o), .phys_size_o(phys_size_o), .phys_wdata_o(phys_wdata_o),
  .phys_be_o(phys_be_o), .rd_data_o(rd_data_o)
);

// File: tb/ecc_inline_mapper_tb.sv
module ecc_inline_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [31:0] cfg_min_i = '0, cfg_max_i = '0;
  logic        cfg_shadow_hi_i = 1'b1;
  logic        cfg_reject_o;
  logic [31:0] sys_addr_i = '0;
  logic [1:0]  sys_size_i = '0;
  logic [31:0] wr_word_i = '0, wr_chk_i = '0;
  logic [63:0] rd_phys_i = '0;
  logic [1:0]  region_o;
  logic [31:0] phys_addr_o;
  logic [1:0]  phys_size_o;
  logic [63:0] phys_wdata_o;
  logic [7:0]  phys_be_o;
  logic [31:0] rd_data_o, rd_chk_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] m_lo = '0, m_hi = '0;
  logic        m_sel = 1'b1;

  always #4 clk = ~clk;

  ecc_inline_mapper dut_i (.*);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] model_be(input logic [2:0] off, input logic [1:0] sz);
    logic [7:0] m;
    int nb, st;
    m  = '0;
    nb = 1 << sz;
    st = int'(off) & ~(nb - 1);
    for (int k = 0; k < nb; k++) m[st + k] = 1'b1;
    return m;
  endfunction

  task automatic do_cfg(input logic [31:0] lo, input logic [31:0] hi, input logic sel, input string req);
    logic ok;
    ok = (lo[15:0] == 16'h0) && (hi[15:0] == 16'h0);
    cfg_min_i = lo; cfg_max_i = hi; cfg_shadow_hi_i = sel; cfg_load_i = 1'b1;
    step();
    cfg_load_i = 1'b0;
    check(req, "cfg_reject", {63'b0, cfg_reject_o}, {63'b0, !ok});
    if (ok) begin m_lo = lo; m_hi = hi; m_sel = sel; end
    step();
    check(req, "cfg_reject clears", {63'b0, cfg_reject_o}, 64'd0);
  endtask

  task automatic do_access(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] w,
                           input logic [31:0] c, input string req);
    logic [1:0]  e_rgn;
    logic [31:0] e_pa;
    logic [1:0]  e_sz;
    logic [63:0] e_wd;
    logic [7:0]  e_be;
    logic [7:0]  sbe;
    sys_addr_i = a; sys_size_i = sz; wr_word_i = w; wr_chk_i = c;
    if (a >= m_lo && a < m_hi) begin
      e_rgn = 2'd1;
      e_pa  = 2 * a - m_lo;
      e_sz  = (sz == 2'd3) ? 2'd3 : sz + 2'd1;
      for (int i = 0; i < 4; i++) e_wd[16*i +: 16] = {c[8*i +: 8], w[8*i +: 8]};
      sbe = (sz == 2'd3) ? 8'h0F : model_be({1'b0, a[1:0]}, sz);
      for (int i = 0; i < 4; i++) e_be[2*i +: 2] = {2{sbe[i]}};
    end else begin
      if (m_hi > m_lo && a >= m_hi && {1'b0, a} < {1'b0, m_hi} + {1'b0, m_hi - m_lo}) begin
        e_rgn = 2'd2;
        e_pa  = m_sel ? a : a - (m_hi - m_lo);
      end else begin
        e_rgn = 2'd0;
        e_pa  = a;
      end
      e_sz = sz;
      e_wd = {w, w};
      e_be = model_be(a[2:0], sz);
    end
    step();
    check(req, "region", {62'b0, region_o}, {62'b0, e_rgn});
    check(req, "phys_addr", {32'b0, phys_addr_o}, {32'b0, e_pa});
    check(req, "phys_size", {62'b0, phys_size_o}, {62'b0, e_sz});
    check(req, "phys_wdata", phys_wdata_o, e_wd);
    check(req, "phys_be", {56'b0, phys_be_o}, {56'b0, e_be});
  endtask

  task automatic t_reset();
    check("R1", "region in reset", {62'b0, region_o}, 64'd0);
    check("R1", "phys_addr in reset", {32'b0, phys_addr_o}, 64'd0);
    check("R1", "reject in reset", {63'b0, cfg_reject_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    do_access(32'h1234_5678, 2'd2, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R1 R10 empty window");
  endtask

  task automatic t_protected();
    do_cfg(32'h8000_0000, 32'hA000_0000, 1'b1, "R2 aligned load");
    do_access(32'h9000_0000, 2'd2, 32'h1122_3344, 32'hC990_39ED, "R4 R5 R6 word");
    check("R5", "example pack", phys_wdata_o, 64'hC9119022_3933ED44);
    do_access(32'h8000_0000, 2'd2, 32'hA5A5_0F0F, 32'h0102_0304, "R3 min bound");
    do_access(32'h9FFF_FFFF, 2'd0, 32'h0000_00AA, 32'h5500_0000, "R3 R6 max-1 byte");
    do_access(32'h8000_0002, 2'd1, 32'hBEEF_0000, 32'h1234_0000, "R4 R6 half");
    do_access(32'h8000_0010, 2'd3, 32'h7777_8888, 32'h9999_AAAA, "R4 x64 stays");
  endtask

  task automatic t_shadow();
    do_access(32'hA000_0000, 2'd2, 32'h3933_ED45, 32'h1111_1111, "R3 R7 R8 max is shadow");
    check("R8", "shadow maps to image of 0x90000000", {32'b0, phys_addr_o}, 64'hA000_0000);
    do_access(32'hBFFF_FFFF, 2'd0, 32'h0000_0001, 32'h2222_2222, "R7 R9 shadow end");
    do_access(32'hC000_0000, 2'd2, 32'h4444_5555, 32'h6666_7777, "R10 past shadow");
    do_access(32'h7FFF_FFFC, 2'd2, 32'h0BAD_F00D, 32'h1357_9BDF, "R10 below min");
    do_cfg(32'h8000_0000, 32'hA000_0000, 1'b0, "R2 select low");
    do_access(32'hA000_0000, 2'd2, 32'hCAFE_0001, 32'hFACE_FACE, "R8 select 0");
    do_access(32'hA000_0006, 2'd1, 32'h1234_5678, 32'h0, "R8 R9 select 0 half");
  endtask

  task automatic t_reject();
    do_cfg(32'h8000_8000, 32'hA000_0000, 1'b1, "R2 misaligned min");
    do_cfg(32'h4000_0000, 32'h5000_0100, 1'b1, "R2 misaligned max");
    do_access(32'h9000_0000, 2'd2, 32'h0102_0304, 32'h0506_0708, "R2 bounds kept");
    check("R2", "old window still used", {32'b0, phys_addr_o}, 64'hA000_0000);
    do_cfg(32'hC200_0000, 32'hC201_0000, 1'b1, "R2 small window");
    do_access(32'hC200_8000, 2'd2, 32'h1122_3344, 32'h0, "R4 small window");
    do_access(32'hC201_0000, 2'd2, 32'h0, 32'h0, "R8 small shadow");
  endtask

  task automatic t_read();
    rd_phys_i = 64'hC9119022_3933ED44;
    step();
    check("R11", "rd_data", {32'b0, rd_data_o}, 64'h1122_3344);
    check("R11", "rd_chk", {32'b0, rd_chk_o}, 64'hC990_39ED);
    rd_phys_i = 64'h0123_4567_89AB_CDEF;
    step();
    check("R11", "rd_data 2", {32'b0, rd_data_o}, 64'h2367_ABEF);
    check("R11", "rd_chk 2", {32'b0, rd_chk_o}, 64'h0145_89CD);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_protected();
    t_shadow();
    t_reject();
    t_read();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule